// File: doc/BRIEF.md
# Low-Frequency Reader Carrier and Sample Streamer

This block sits between the analog side of a low-frequency RFID reader and a host processor. From one 24 MHz main clock it builds a synchronous serial bit clock. It divides that clock by eight to get the square wave that drives the reader coil, and it uses the same divided clock as the ADC sample clock. One input picks the carrier frequency: 125 kHz when the select bit is 1, about 136 kHz when it is 0.

Once per carrier period the block captures the 8-bit ADC word. It then shifts the word to the host, most significant bit first, with a frame strobe marking the bits. All outputs come from registers clocked by the main clock. The serial data changes only where the serial clock falls, so the host samples on the rising edge. The high-frequency clock inputs, the serial data-in line and the comparator inputs are present but have no effect.

Top module: `lf_adc_streamer`

## Requirements
- R1: After reset, `ser_clk` is low. Its half-period is 11 + `sel_125k` main-clock cycles, so the first rising edge follows the (11 + sel)-th clock and the full period is 2*(11 + sel) cycles.
- R2: A change on `sel_125k` is adopted only when a half-period ends. The half-period already in progress finishes at the old length, so no shortened pulse appears.
- R3: `coil_lo` changes only on falling edges of `ser_clk`. It is low for the first four serial periods after reset, high for the next four, and repeats that pattern, giving a frequency of `ser_clk`/8.
- R4: `adc_clk` and `dbg` carry the same waveform as `coil_lo`. The ADC word on `adc_d` is captured on the main-clock edge where `adc_clk` falls, which is the eighth `ser_clk` falling edge of each carrier period.
- R5: `ser_data` shows the captured word most significant bit first. The next bit appears on each `ser_clk` falling edge, so bit 7 appears on the capture edge and bit 0 on the seventh falling edge after it. `ser_data` changes at no other time.
- R6: `ser_frame` stays low from reset until the first capture. It goes high in the same slot as the first MSB and stays high while bits are being shifted. Before the first capture, `ser_data` is low.
- R7: A synchronous `rst` clears all dividers and the shift register. One clock edge later, `ser_clk`, `coil_lo`, `adc_clk`, `dbg`, `ser_frame` and `ser_data` are all low.
- R8: `coil_hi` and all bits of `coil_oe` are held low. `hf_clk_p`, `hf_clk_n`, `host_sdo`, `cmp_hi` and `cmp_lo` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz main clock |
| rst | input | 1 | synchronous reset, active high |
| sel_125k | input | 1 | carrier select: 1 gives 125 kHz, 0 gives about 136 kHz |
| adc_d | input | 8 | ADC output word |
| hf_clk_p | input | 1 | high-frequency clock, ignored |
| hf_clk_n | input | 1 | complementary high-frequency clock, ignored |
| host_sdo | input | 1 | serial data from the host, ignored |
| cmp_hi | input | 1 | high comparator input, ignored |
| cmp_lo | input | 1 | low comparator input, ignored |
| coil_lo | output | 1 | low-frequency coil drive square wave |
| coil_hi | output | 1 | high-frequency coil drive, tied low |
| coil_oe | output | 4 | coil output enables, tied low |
| adc_clk | output | 1 | ADC sample clock |
| ser_frame | output | 1 | frame strobe for the serial stream |
| ser_data | output | 1 | serial sample data, MSB first |
| ser_clk | output | 1 | serial bit clock |
| dbg | output | 1 | copy of `adc_clk` |

## Verification
The bench compares every output in every cycle with a closed-form model, over several carrier periods at both select values. This catches a half-period off by one, which would slowly move every edge away from its predicted cycle. It also catches a word captured one slot late or shifted LSB first, either of which shows up as wrong data bits. A select change made in the middle of a half-period shows whether a divider adopts the new length immediately: such a design makes the serial clock rise a cycle early. The bench checks the first capture boundary, where a design that raises the frame or shows data before the eighth falling edge gives itself away. It also checks a reset applied in the middle of a stream and toggles every ignored input throughout the run.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  // Last count of a serial-clock half period for a given select value.
  function automatic int unsigned half_last(input int unsigned base, input logic sel);
    return base + (sel ? 1 : 0) - 1;
  endfunction

  // True when a bit-slot index is the final slot of a carrier period.
  function automatic logic slot_is_last(input int unsigned idx, input int unsigned slots);
    return idx == slots - 1;
  endfunction

endpackage

// File: rtl/lfs_sclk_gen.sv
module lfs_sclk_gen #(
  parameter int unsigned BASE_HALF = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  output logic sclk,
  output logic tc_ev,
  output logic fall_ev
);
  localparam int unsigned CW = $clog2(BASE_HALF + 2);

  logic [CW-1:0] hcnt;
  logic          sel_q;
  logic [CW-1:0] limit;

  always_comb begin
    limit = CW'(lfs_pkg::half_last(BASE_HALF, sel_q));
  end

  assign tc_ev   = (hcnt == limit);
  assign fall_ev = tc_ev && sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      sclk  <= 1'b0;
      sel_q <= sel_in;
    end else if (tc_ev) begin
      hcnt  <= '0;
      sclk  <= ~sclk;
      sel_q <= sel_in;
    end else begin
      hcnt  <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/lfs_carrier_div.sv
module lfs_carrier_div #(
  parameter int unsigned SLOTS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_ev,
  output logic carrier,
  output logic wrap_ev
);
  localparam int unsigned IW = $clog2(SLOTS);

  logic [IW-1:0] idx;

  assign wrap_ev = fall_ev && lfs_pkg::slot_is_last(int'(idx), SLOTS);
  assign carrier = idx[IW-1];

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (fall_ev) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/lfs_serializer.sv
module lfs_serializer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_ev,
  input  logic         load_ev,
  input  logic [W-1:0] word,
  output logic         frame,
  output logic         dout
);
  logic [W-1:0] sreg;

  assign dout = sreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      frame <= 1'b0;
    end else if (load_ev) begin
      sreg  <= word;
      frame <= 1'b1;
    end else if (shift_ev) begin
      sreg  <= {sreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/lf_adc_streamer.sv
module lf_adc_streamer #(
  parameter int unsigned BASE_HALF = 11,
  parameter int unsigned SAMPLE_W  = 8,
  parameter int unsigned OE_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_125k,
  input  logic [SAMPLE_W-1:0] adc_d,
  input  logic                hf_clk_p,
  input  logic                hf_clk_n,
  input  logic                host_sdo,
  input  logic                cmp_hi,
  input  logic                cmp_lo,
  output logic                coil_lo,
  output logic                coil_hi,
  output logic [OE_W-1:0]     coil_oe,
  output logic                adc_clk,
  output logic                ser_frame,
  output logic                ser_data,
  output logic                ser_clk,
  output logic                dbg
);
  // Named internal events, visible to the bound checker.
  logic tc_ev;
  logic fall_ev;
  logic load_ev;
  logic carrier;

  logic unused_inputs;
  assign unused_inputs = ^{hf_clk_p, hf_clk_n, host_sdo, cmp_hi, cmp_lo};

  lfs_sclk_gen #(.BASE_HALF(BASE_HALF)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .sel_in (sel_125k),
    .sclk   (ser_clk),
    .tc_ev  (tc_ev),
    .fall_ev(fall_ev)
  );

  lfs_carrier_div #(.SLOTS(SAMPLE_W)) u_car (
    .clk    (clk),
    .rst    (rst),
    .fall_ev(fall_ev),
    .carrier(carrier),
    .wrap_ev(load_ev)
  );

  lfs_serializer #(.W(SAMPLE_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .shift_ev(fall_ev),
    .load_ev (load_ev),
    .word    (adc_d),
    .frame   (ser_frame),
    .dout    (ser_data)
  );

  assign coil_lo = carrier;
  assign adc_clk = carrier;
  assign dbg     = carrier;
  assign coil_hi = 1'b0;
  assign coil_oe = '0;
endmodule

// File: rtl/lf_adc_streamer_chk.sv
module lf_adc_streamer_chk (
  input logic clk,
  input logic rst,
  input logic ser_clk,
  input logic ser_data,
  input logic ser_frame,
  input logic coil_lo,
  input logic adc_clk,
  input logic tc_ev,
  input logic fall_ev,
  input logic load_ev
);
  // R1
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_clk) |-> $past(tc_ev));

  // R3
  carrier_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(coil_lo) |-> $past(fall_ev));

  // R4
  adc_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_clk) |-> $past(load_ev));

  // R5
  data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_data) |-> $past(fall_ev));

  // R6
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load_ev) |-> ser_frame);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ser_clk && !ser_data && !ser_frame && !coil_lo));
endmodule

bind lf_adc_streamer lf_adc_streamer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .ser_frame(ser_frame),
  .coil_lo  (coil_lo),
  .adc_clk  (adc_clk),
  .tc_ev    (tc_ev),
  .fall_ev  (fall_ev),
  .load_ev  (load_ev)
);

// File: tb/sim_lf_adc_streamer.sv
module sim_lf_adc_streamer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b1;
  logic [7:0] adc = 8'h00;
  logic       hfp = 1'b0, hfn = 1'b0, sdo = 1'b0, chi = 1'b0, clo = 1'b0;
  logic       coil_lo, coil_hi, adc_clk, frm, sdat, sclk, dbg;
  logic [3:0] coil_oe;
  int kcnt = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lf_adc_streamer u0 (
    .clk(clk), .rst(rst), .sel_125k(sel), .adc_d(adc),
    .hf_clk_p(hfp), .hf_clk_n(hfn), .host_sdo(sdo), .cmp_hi(chi), .cmp_lo(clo),
    .coil_lo(coil_lo), .coil_hi(coil_hi), .coil_oe(coil_oe), .adc_clk(adc_clk),
    .ser_frame(frm), .ser_data(sdat), .ser_clk(sclk), .dbg(dbg)
  );

  // Clock edges since reset release.
  always @(posedge clk) begin
    if (rst) kcnt <= 0;
    else     kcnt <= kcnt + 1;
  end

  function automatic logic [7:0] adc_pat(input int x);
    return 8'((x * 37 + 91) % 256);
  endfunction

  // ADC word and ignored inputs change away from the active edge (R8 stimulus).
  always @(negedge clk) begin
    adc <= adc_pat(kcnt);
    hfp <= kcnt[0];
    hfn <= ~kcnt[0];
    sdo <= kcnt[1];
    chi <= kcnt[2];
    clo <= kcnt[3];
  end

  // Expected {sclk, carrier, frame, data} after edge k, with half period h.
  function automatic logic [3:0] model(input int k, input int h);
    int p, n, m;
    logic [7:0] s;
    logic e_clk, e_car, e_frm, e_dat;
    p = 2 * h;
    n = k / p;
    m = n / 8;
    e_clk = ((k / h) % 2) == 1;
    e_car = (n % 8) >= 4;
    e_frm = n >= 8;
    s = adc_pat(m * 8 * p - 1);
    e_dat = e_frm ? s[7 - (n % 8)] : 1'b0;
    return {e_clk, e_car, e_frm, e_dat};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at k=%0d", req, act, exp, kcnt);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1;
    sel = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_k(input int k);
    while (kcnt != k) @(negedge clk);
  endtask

  // sel, k, ser_clk, coil_lo, ser_frame
  localparam int VT [0:9][0:4] = '{
    '{1,  11, 0, 0, 0}, '{1,  12, 1, 0, 0}, '{1,  24, 0, 0, 0},
    '{1,  96, 0, 1, 0}, '{1, 191, 1, 1, 0}, '{1, 192, 0, 0, 1},
    '{0,  11, 1, 0, 0}, '{0,  22, 0, 0, 0}, '{0,  88, 0, 1, 0},
    '{0, 176, 0, 0, 1}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    // Reset state (R7, R8)
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset outputs", {sclk, coil_lo, adc_clk, dbg, frm, sdat}, 6'b0);
    chk("R8 tied outputs", {coil_hi, coil_oe}, 5'b0);

    // Vector table: edge positions (R1, R3, R4, R6)
    for (int v = 0; v < 10; v++) begin
      do_reset(VT[v][0] != 0);
      wait_k(VT[v][1]);
      chk("R1 ser_clk", sclk, VT[v][2]);
      chk("R3 coil_lo", coil_lo, VT[v][3]);
      chk("R4 adc_clk/dbg", {adc_clk, dbg}, {2{VT[v][3] != 0}});
      chk("R6 ser_frame", frm, VT[v][4]);
    end

    // Full-stream compare every cycle, both selects (R1 R3 R5 R6 R8)
    for (int s = 1; s >= 0; s--) begin
      do_reset(s != 0);
      for (int k = 1; k <= 800; k++) begin
        wait_k(k);
        chk("R5 stream {clk,car,frm,dat}", {sclk, coil_lo, frm, sdat}, model(k, 11 + s));
        chk("R8 tied outputs", {coil_hi, coil_oe}, 5'b0);
      end
    end

    // Mid-stream reset (R7)
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 mid-stream reset", {sclk, coil_lo, adc_clk, dbg, frm, sdat}, 6'b0);
    @(negedge clk);
    rst = 1'b0;

    // Select change mid half-period (R2)
    do_reset(1'b1);
    wait_k(5);
    sel = 1'b0;
    wait_k(11);
    chk("R2 old half kept", sclk, 1'b0);
    wait_k(12);
    chk("R2 rise at old length", sclk, 1'b1);
    wait_k(22);
    chk("R2 new half running", sclk, 1'b1);
    wait_k(23);
    chk("R2 fall at new length", sclk, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule